// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block turns a set of already digitised supervisory conditions into one clean, timed system reset. It watches a flag that says the main supply is above its trip point, the sensed levels of two bidirectional reset pins (one active-high, one active-low), and a single-cycle watchdog expiry pulse. From these it drives the output enables of the two reset pins, which model open-drain drivers. The active-high pin is pulled up by its enable. The active-low pin is pulled down by its enable. The two pins therefore always show complementary levels.

A low supply holds reset for as long as it lasts. A return of the supply, a sensed edge on either reset pin, or a watchdog pulse each start a full timeout of `TIMEOUT_CYCLES` clock cycles. Any new trigger during a running timeout restarts the count from zero. The supply flag is synchronised and then debounced, so that short dips are discarded. The pin levels are synchronised before edge detection. Edges that the block itself causes on a pin are not taken as requests.

A separate auxiliary under-voltage flag passes straight through to a low-voltage output with no clocking and no timer.

Top module: `rsq_reset_seq`

## Requirements
- R1: From the synchronous reset `rst` onward, both reset enables are active until a trigger-free timeout has completed. While `rst` is high, both enables are active.
- R2: While the debounced supply flag reads low, both reset enables stay active for any length of time.
- R3: After `supply_ok_i` rises and stays high, the enables stay active for exactly SYNC_STAGES+GLITCH_CYCLES+TIMEOUT_CYCLES-1 sampled cycles, counted from the first clock edge after the change, and are then released.
- R4: A drop of `supply_ok_i` that lasts at least GLITCH_CYCLES cycles turns the enables on in the (SYNC_STAGES+GLITCH_CYCLES+1)th cycle after the drop. No timeout is waited for.
- R5: A low pulse on `supply_ok_i` that is shorter than GLITCH_CYCLES cycles leaves both enables inactive.
- R6: `rst_hi_oe_o` and `rst_lo_oe_o` are equal in every cycle, so the active-high pin reads high exactly when the active-low pin reads low.
- R7: A high-to-low change of `pin_lo_i`, while the block is not driving, activates the enables from the (SYNC_STAGES+1)th cycle after the change for exactly TIMEOUT_CYCLES cycles.
- R8: A low-to-high change of `pin_hi_i`, while the block is not driving, activates the enables with the same delay and for the same length as in R7.
- R9: Pin edges that arrive while the block drives the pins, or within SYNC_STAGES+1 cycles after it stops, are ignored. With the pins wired back to the enables, a watchdog reset therefore lasts exactly TIMEOUT_CYCLES cycles.
- R10: A one-cycle high pulse on `wdt_expire_i` activates the enables from the next cycle for exactly TIMEOUT_CYCLES cycles.
- R11: A trigger during a running timeout restarts the count. Two watchdog pulses D cycles apart (D < TIMEOUT_CYCLES) give D+TIMEOUT_CYCLES active cycles.
- R12: `vlow_o` equals `aux_low_i` with no clocking. The auxiliary flag has no effect on the reset enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Asynchronous flag, high when the main supply is above its trip point |
| aux_low_i | input | 1 | Auxiliary sense flag, high on under-voltage |
| pin_hi_i | input | 1 | Sensed level of the active-high reset pin (asynchronous) |
| pin_lo_i | input | 1 | Sensed level of the active-low reset pin (asynchronous) |
| wdt_expire_i | input | 1 | Single-cycle watchdog expiry pulse, synchronous to clk |
| rst_hi_oe_o | output | 1 | Enable that pulls the active-high reset pin high |
| rst_lo_oe_o | output | 1 | Enable that pulls the active-low reset pin low |
| vlow_o | output | 1 | Unclocked auxiliary low-voltage flag |

## Verification
The bench applies five kinds of stimulus and measures, for each one, the first active cycle and the total active length:

- **Supply return:** the length separates the synchroniser, debounce and timeout latencies.
- **Supply dip shorter than the debounce window:** this separates filtering from edge sensing.
- **External edge on each pin:** this confirms the direction of edge that each pin honours.
- **Watchdog pulse:** the pins are wired back to the enables, so this also shows whether the block's own drive edge is masked. Without the mask, the edge would add SYNC_STAGES+1 cycles.
- **Two closely spaced watchdog pulses:** these tell a restarting count from a count that only extends or ignores a new trigger.

The auxiliary flag is toggled while the reset outputs are idle, to show that it passes through without touching them.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // Trigger sources that start or hold the reset timeout.
  typedef struct packed {
    logic supply_low;
    logic pin_lo_fall;
    logic pin_hi_rise;
    logic wdt;
  } rsq_trig_t;

  function automatic int rsq_cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/rsq_glitch_filter.sv
module rsq_glitch_filter #(
  parameter int   HOLD    = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int CW = rsq_pkg::rsq_cnt_w(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= RST_VAL;
      run_q  <= '0;
    end else if (d_i != filt_q) begin
      if (run_q == LAST) begin
        filt_q <= d_i;
        run_q  <= '0;
      end else begin
        run_q  <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign q_o = filt_q;

  AST_FILT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (d_i == filt_q) |=> $stable(filt_q)); // R5

endmodule

// File: rtl/rsq_pin_edge.sv
module rsq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_hi_s_i,
  input  logic pin_lo_s_i,
  input  logic drive_i,
  output logic hi_rise_o,
  output logic lo_fall_o
);

  localparam int HW = SYNC_STAGES + 1;

  logic          hi_prev_q;
  logic          lo_prev_q;
  logic [HW-1:0] drv_hist_q;
  logic          mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_prev_q  <= 1'b1;
      lo_prev_q  <= 1'b0;
      drv_hist_q <= '1;
    end else begin
      hi_prev_q  <= pin_hi_s_i;
      lo_prev_q  <= pin_lo_s_i;
      drv_hist_q <= {drv_hist_q[HW-2:0], drive_i};
    end
  end

  // Own drive reaches the sensed pins after the synchroniser delay.
  assign mask      = drive_i | (|drv_hist_q);
  assign hi_rise_o = !mask && !hi_prev_q && pin_hi_s_i;
  assign lo_fall_o = !mask && lo_prev_q && !pin_lo_s_i;

  AST_MASK_HI: assert property (@(posedge clk) disable iff (rst)
    drive_i |-> !hi_rise_o); // R9
  AST_MASK_LO: assert property (@(posedge clk) disable iff (rst)
    drive_i |-> !lo_fall_o); // R9

endmodule

// File: rtl/rsq_timeout.sv
module rsq_timeout #(
  parameter int TIMEOUT_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic active_o
);

  localparam int CW = rsq_pkg::rsq_cnt_w(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = busy_q;

  AST_TRIG_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> (active_o && cnt_q == '0)); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (cnt_q <= LAST)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !trig_i) |=> !active_o); // R10

endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq #(
  parameter int SYNC_STAGES    = 2,
  parameter int GLITCH_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic aux_low_i,
  input  logic pin_hi_i,
  input  logic pin_lo_i,
  input  logic wdt_expire_i,
  output logic rst_hi_oe_o,
  output logic rst_lo_oe_o,
  output logic vlow_o
);

  import rsq_pkg::*;

  logic [2:0] raw_in;
  logic [2:0] syn_in;
  logic       supply_filt;
  logic       hi_rise;
  logic       lo_fall;
  logic       active;
  rsq_trig_t  trig;

  // bit 2: supply, bit 1: active-high pin, bit 0: active-low pin
  assign raw_in = {supply_ok_i, pin_hi_i, pin_lo_i};

  rsq_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(raw_in),
    .q_o(syn_in)
  );

  rsq_glitch_filter #(
    .HOLD   (GLITCH_CYCLES),
    .RST_VAL(1'b0)
  ) u_filt (
    .clk(clk),
    .rst(rst),
    .d_i(syn_in[2]),
    .q_o(supply_filt)
  );

  rsq_pin_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rst       (rst),
    .pin_hi_s_i(syn_in[1]),
    .pin_lo_s_i(syn_in[0]),
    .drive_i   (active),
    .hi_rise_o (hi_rise),
    .lo_fall_o (lo_fall)
  );

  always_comb begin
    trig.supply_low  = !supply_filt;
    trig.pin_lo_fall = lo_fall;
    trig.pin_hi_rise = hi_rise;
    trig.wdt         = wdt_expire_i;
  end

  rsq_timeout #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (|trig),
    .active_o(active)
  );

  assign rst_hi_oe_o = active;
  assign rst_lo_oe_o = active;
  assign vlow_o      = aux_low_i;

  AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !supply_filt |=> rst_hi_oe_o); // R2
  AST_WDT_RESET: assert property (@(posedge clk) disable iff (rst)
    wdt_expire_i |=> (rst_hi_oe_o && rst_lo_oe_o)); // R10

endmodule

// File: tb/rsq_reset_seq_tb_top.sv
`timescale 1ns/1ps
module rsq_reset_seq_tb_top;

  localparam int SYNC = 2;
  localparam int GL   = 4;
  localparam int TMO  = 20;

  typedef struct {
    string tag;
    int    val;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic aux_low = 1'b0;
  logic ext_hi = 1'b0;
  logic ext_lo = 1'b1;
  logic wdt = 1'b0;
  logic pin_hi, pin_lo;
  logic hi_oe, lo_oe, vlow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  item_t exp_q[$];
  item_t act_q[$];

  always #4 clk = ~clk;

  // Open-drain pin model: external source wired with the block's drive.
  assign pin_hi = ext_hi | hi_oe;
  assign pin_lo = ext_lo & ~lo_oe;

  rsq_reset_seq #(
    .SYNC_STAGES   (SYNC),
    .GLITCH_CYCLES (GL),
    .TIMEOUT_CYCLES(TMO)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok),
    .aux_low_i   (aux_low),
    .pin_hi_i    (pin_hi),
    .pin_lo_i    (pin_lo),
    .wdt_expire_i(wdt),
    .rst_hi_oe_o (hi_oe),
    .rst_lo_oe_o (lo_oe),
    .vlow_o      (vlow)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compares actual results against expectations in order.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e;
      item_t a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      check(e.tag, a.val, e.val);
    end
  end

  task automatic expect_item(input string tag, input int v);
    exp_q.push_back('{tag, v});
  endtask

  // Samples WIN cycles; reports the first active index, active count, and pairing.
  task automatic measure(input string tag, input int win,
                         input int exp_first, input int exp_cnt);
    int first = 0;
    int cnt = 0;
    int split = 0;
    expect_item({tag, " first-active"}, exp_first);
    expect_item({tag, " active-count"}, exp_cnt);
    expect_item("R6 enable pairing mismatches", 0);
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (hi_oe !== lo_oe) split++;
      if (hi_oe === 1'b1) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    act_q.push_back('{{tag, " first-active"}, first});
    act_q.push_back('{{tag, " active-count"}, cnt});
    act_q.push_back('{"R6 enable pairing mismatches", split});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hi enable in reset", int'(hi_oe), 1);
    check("R1 lo enable in reset", int'(lo_oe), 1);
    rst = 1'b0;

    // R2: supply low keeps reset active indefinitely
    measure("R2 supply held low", 40, 1, 40);

    // R3: supply return
    supply_ok = 1'b1;
    measure("R3 supply return", SYNC + GL + TMO + 20, 1, SYNC + GL + TMO - 1);

    // R12: auxiliary flag passes through, no reset effect
    @(negedge clk);
    aux_low = 1'b1;
    #1;
    check("R12 vlow follows aux high", int'(vlow), 1);
    measure("R12 reset untouched by aux", 20, 0, 0);
    aux_low = 1'b0;
    #1;
    check("R12 vlow follows aux low", int'(vlow), 0);

    // R5: short supply dip ignored
    @(negedge clk);
    supply_ok = 1'b0;
    fork
      begin
        repeat (GL - 1) @(negedge clk);
        supply_ok = 1'b1;
      end
    join_none
    measure("R5 short supply dip", 40, 0, 0);

    // R4: long supply drop asserts reset without timeout
    supply_ok = 1'b0;
    measure("R4 supply drop", 30, SYNC + GL + 1, 30 - SYNC - GL);
    supply_ok = 1'b1;
    measure("R3 supply recovery", SYNC + GL + TMO + 20, 1, SYNC + GL + TMO - 1);

    // R7: external falling edge on the active-low pin
    ext_lo = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        ext_lo = 1'b1;
      end
    join_none
    measure("R7 low pin fall", TMO + 20, SYNC + 1, TMO);

    // R8: external rising edge on the active-high pin
    ext_hi = 1'b1;
    fork
      begin
        repeat (3) @(negedge clk);
        ext_hi = 1'b0;
      end
    join_none
    measure("R8 high pin rise", TMO + 20, SYNC + 1, TMO);

    // R10 and R9: watchdog pulse; own pin drive must not retrigger
    wdt = 1'b1;
    fork
      begin
        @(negedge clk);
        wdt = 1'b0;
      end
    join_none
    measure("R10 R9 watchdog pulse", TMO + 20, 1, TMO);

    // R11: second pulse restarts the count
    wdt = 1'b1;
    fork
      begin
        @(negedge clk);
        wdt = 1'b0;
        repeat (6) @(negedge clk);
        wdt = 1'b1;
        @(negedge clk);
        wdt = 1'b0;
      end
    join_none
    measure("R11 retrigger", TMO + 30, 1, 7 + TMO);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule